// File: doc/BRIEF.md
# Biphase-Mark Timing Command Transmitter

This block drives a single serial timing line for a bunch-crossing synchronous system. Every bunch-clock period carries two logical bits. The first is a trigger-accept bit (channel A). The second is one bit of a slow command channel (channel B). Both bits are placed on one wire using biphase-mark line coding. The block runs from a line clock at four times the bunch rate. A free-running two-bit phase counter splits each bunch period into an A cell and a B cell, each two line-clock ticks long.

Channel B idles at 1. It carries 16-bit broadcast frames, and each frame holds one 8-bit command protected by five check bits. Once per orbit the block queues a bunch-count-reset command on its own; a disable input can suppress it. Software can also request any command byte, such as orbit-count reset (0x28) or event-count reset (0x02). It does so by presenting the byte and raising a request level. Only the rising edge of the request counts. When both sources are waiting, the periodic reset goes first.

Top module: `bmt_timing_tx`

## Requirements
- R1: While rst_n is low, line_o is 0 and no frame is pending. After release the first line-clock edge is phase 0, and phases then run 0,1,2,3 repeatedly; one bunch period is four line clocks.
- R2: line_o inverts on every phase-0 edge (start of the A cell) and every phase-2 edge (start of the B cell).
- R3: trig_i is sampled on each phase-3 edge and becomes the A bit of the next bunch period. line_o inverts on the phase-1 edge exactly when that A bit is 1.
- R4: line_o inverts on the phase-3 edge exactly when the current B bit is 1. The B bit is 1 whenever no frame bit is being sent.
- R5: A frame is 16 B bits sent first-to-last as follows: 0 (start), 0 (format), command bits 7 down to 0, check bits c4 down to c0, then 1 (stop). With d the command, c0 = parity of d&0x0F, c1 = parity of d&0x71, c2 = parity of d&0xB6, c3 = parity of d&0xDA, and c4 = parity of d together with c0..c3.
- R6: The command 0x01 is queued on the phase-3 edge that ends bunch period number k·ORBIT_LEN−1 after reset (k ≥ 1, default ORBIT_LEN 3563). When the channel is free, its frame starts in the next bunch period, giving one frame per orbit.
- R7: If bcr_dis_i is 1 on the edge where the orbit wraps, no 0x01 frame is queued for that orbit.
- R8: A rising edge of send_req_i captures cmd_byte_i and sends exactly one frame with that byte (including 0x28 and 0x02). Holding send_req_i high sends nothing more.
- R9: If the periodic 0x01 and a software command are both waiting when the channel frees, the 0x01 frame is sent first and the software frame follows it.
- R10: At least one idle B bit of 1 separates the stop bit of one frame from the start bit of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, four times the bunch rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger accept for the current bunch period |
| cmd_byte_i | input | 8 | Software command byte |
| send_req_i | input | 1 | Send request; its rising edge queues cmd_byte_i |
| bcr_dis_i | input | 1 | Suppresses the periodic bunch-count reset |
| line_o | output | 1 | Biphase-mark encoded serial line |

## Verification
The line is driven by a pseudo-random trigger pattern over four orbits, so A cells with both values fall under idle B bits as well as under frame bits. Software commands are tried in several ways. One has its request held high for a hundred bunch periods, which separates edge from level sensitivity. One pair of requests arrives three bunches apart, so the second must wait out a busy frame and the idle gap. One request arrives in the same bunch as the orbit wrap, which exposes the priority order. Disabling the periodic reset across exactly one wrap shows that only that orbit's reset frame disappears. An independent decoder recovers frames from the line and checks their check bits, their spacing and their order.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  localparam int CMD_W   = 8;
  localparam int CHK_W   = 5;
  localparam int FRAME_W = 2 + CMD_W + CHK_W + 1;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  typedef logic [CMD_W-1:0]   cmd_t;
  typedef logic [CHK_W-1:0]   chk_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {
    PH_A_EDGE = 2'd0,
    PH_A_MID  = 2'd1,
    PH_B_EDGE = 2'd2,
    PH_B_MID  = 2'd3
  } phase_e;

  // Five check bits over an 8-bit command
  function automatic chk_t cmd_check(input cmd_t d);
    chk_t c;
    c[0] = d[0] ^ d[1] ^ d[2] ^ d[3];
    c[1] = d[0] ^ d[4] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[4] ^ d[5] ^ d[7];
    c[3] = d[1] ^ d[3] ^ d[4] ^ d[6] ^ d[7];
    c[4] = (^d) ^ (^c[3:0]);
    return c;
  endfunction

  // Frame laid out MSB first: start, format, command, checks, stop
  function automatic frame_t make_frame(input cmd_t d);
    return {1'b0, 1'b0, d, cmd_check(d), 1'b1};
  endfunction

endpackage

// File: rtl/bmt_phase_gen.sv
module bmt_phase_gen
  import bmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph_o,
  output logic   tick_o
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_q + 2'd1;
  end

  assign ph_o   = phase_e'(cnt_q);
  assign tick_o = (cnt_q == 2'd3);

endmodule

// File: rtl/bmt_orbit_timer.sv
module bmt_orbit_timer #(
  parameter int ORBIT_LEN = 3563
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic wrap_o
);

  localparam int ORB_W = $clog2(ORBIT_LEN);
  localparam logic [ORB_W-1:0] LAST = ORB_W'(ORBIT_LEN - 1);

  logic [ORB_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = tick_i & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/bmt_cmd_arbiter.sv
module bmt_cmd_arbiter
  import bmt_pkg::*;
#(
  parameter cmd_t BCR_CODE = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ready_i,
  input  logic wrap_i,
  input  logic bcr_dis_i,
  input  logic send_req_i,
  input  cmd_t cmd_byte_i,
  output logic load_o,
  output logic load_bcr_o,
  output cmd_t load_byte_o,
  output logic bcr_pend_o,
  output logic sw_pend_o
);

  logic req_q, sw_pend_q, bcr_pend_q;
  cmd_t sw_byte_q;
  logic sw_edge, take_bcr, take_sw;

  assign sw_edge  = send_req_i & ~req_q;
  assign take_bcr = tick_i & ready_i & bcr_pend_q;
  assign take_sw  = tick_i & ready_i & ~bcr_pend_q & sw_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      sw_pend_q  <= 1'b0;
      bcr_pend_q <= 1'b0;
      sw_byte_q  <= '0;
    end else begin
      req_q      <= send_req_i;
      sw_pend_q  <= (sw_pend_q & ~take_sw) | sw_edge;
      bcr_pend_q <= (bcr_pend_q & ~take_bcr) | (wrap_i & ~bcr_dis_i);
      if (sw_edge) sw_byte_q <= cmd_byte_i;
    end
  end

  assign load_o      = take_bcr | take_sw;
  assign load_bcr_o  = take_bcr;
  assign load_byte_o = take_bcr ? BCR_CODE : sw_byte_q;
  assign bcr_pend_o  = bcr_pend_q;
  assign sw_pend_o   = sw_pend_q;

endmodule

// File: rtl/bmt_frame_ser.sv
module bmt_frame_ser
  import bmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  input  cmd_t load_byte_i,
  output logic ready_o,
  output logic b_bit_o
);

  frame_t            sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              gap_q;
  logic              b_q;
  frame_t            fresh;

  assign fresh   = make_frame(load_byte_i);
  assign ready_o = (left_q == '0) & ~gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      gap_q  <= 1'b0;
      b_q    <= 1'b1;
    end else if (tick_i) begin
      if (left_q != '0) begin
        b_q    <= sh_q[FRAME_W-1];
        sh_q   <= {sh_q[FRAME_W-2:0], 1'b1};
        left_q <= left_q - 1'b1;
        if (left_q == LEFT_W'(1)) gap_q <= 1'b1;
      end else if (gap_q) begin
        b_q   <= 1'b1;
        gap_q <= 1'b0;
      end else if (load_i) begin
        b_q    <= fresh[FRAME_W-1];
        sh_q   <= {fresh[FRAME_W-2:0], 1'b1};
        left_q <= LEFT_W'(FRAME_W - 1);
      end else begin
        b_q <= 1'b1;
      end
    end
  end

  assign b_bit_o = b_q;

endmodule

// File: rtl/bmt_line_enc.sv
module bmt_line_enc
  import bmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph_i,
  input  logic   tick_i,
  input  logic   trig_i,
  input  logic   b_bit_i,
  output logic   a_bit_o,
  output logic   line_o
);

  logic a_q, line_q, flip;

  always_comb begin
    flip = 1'b1;
    case (ph_i)
      PH_A_EDGE, PH_B_EDGE: flip = 1'b1;
      PH_A_MID:             flip = a_q;
      PH_B_MID:             flip = b_bit_i;
      default:              flip = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      line_q <= 1'b0;
    end else begin
      if (flip)   line_q <= ~line_q;
      if (tick_i) a_q    <= trig_i;
    end
  end

  assign a_bit_o = a_q;
  assign line_o  = line_q;

endmodule

// File: rtl/bmt_timing_tx.sv
module bmt_timing_tx
  import bmt_pkg::*;
#(
  parameter int   ORBIT_LEN = 3563,
  parameter cmd_t BCR_CODE  = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       send_req_i,
  input  logic       bcr_dis_i,
  output logic       line_o
);

  phase_e ph;
  logic   tick, orbit_wrap, ser_ready, load, load_bcr;
  logic   bcr_pend, sw_pend, a_bit, b_bit;
  cmd_t   load_byte;

  bmt_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .ph_o(ph), .tick_o(tick)
  );

  bmt_orbit_timer #(.ORBIT_LEN(ORBIT_LEN)) u_orbit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wrap_o(orbit_wrap)
  );

  bmt_cmd_arbiter #(.BCR_CODE(BCR_CODE)) u_arb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ready_i(ser_ready),
    .wrap_i(orbit_wrap), .bcr_dis_i(bcr_dis_i), .send_req_i(send_req_i),
    .cmd_byte_i(cmd_byte_i), .load_o(load), .load_bcr_o(load_bcr),
    .load_byte_o(load_byte), .bcr_pend_o(bcr_pend), .sw_pend_o(sw_pend)
  );

  bmt_frame_ser u_ser (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
    .load_byte_i(load_byte), .ready_o(ser_ready), .b_bit_o(b_bit)
  );

  bmt_line_enc u_enc (
    .clk(clk), .rst_n(rst_n), .ph_i(ph), .tick_i(tick), .trig_i(trig_i),
    .b_bit_i(b_bit), .a_bit_o(a_bit), .line_o(line_o)
  );

endmodule

// File: rtl/bmt_timing_tx_chk.sv
module bmt_timing_tx_chk
  import bmt_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   line_o,
  input phase_e ph,
  input logic   tick,
  input logic   a_bit,
  input logic   b_bit,
  input logic   orbit_wrap,
  input logic   bcr_dis_i,
  input logic   send_req_i,
  input logic   bcr_pend,
  input logic   sw_pend,
  input logic   ser_ready,
  input logic   load_bcr
);

  // R2
  cell_edge_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_A_EDGE || ph == PH_B_EDGE) |=> (line_o != $past(line_o)));

  // R3
  a_mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_A_MID) |=> (line_o == ($past(line_o) ^ $past(a_bit))));

  // R4
  b_mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_B_MID) |=> (line_o == ($past(line_o) ^ $past(b_bit))));

  // R7
  bcr_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (orbit_wrap && bcr_dis_i && !bcr_pend) |=> !bcr_pend);

  // R8
  sw_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_pend) |-> $past(send_req_i));

  // R9
  bcr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ser_ready && bcr_pend && sw_pend) |-> load_bcr);

endmodule

bind bmt_timing_tx bmt_timing_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_o(line_o), .ph(ph), .tick(tick),
  .a_bit(a_bit), .b_bit(b_bit), .orbit_wrap(orbit_wrap),
  .bcr_dis_i(bcr_dis_i), .send_req_i(send_req_i), .bcr_pend(bcr_pend),
  .sw_pend(sw_pend), .ser_ready(ser_ready), .load_bcr(load_bcr)
);

// File: tb/bmt_timing_tx_tb.sv
module bmt_timing_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ORBIT      = 3563;
  localparam int TOTAL      = 14300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       req = 1'b0;
  logic       dis = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       line;

  bmt_timing_tx u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .cmd_byte_i(cmd),
    .send_req_i(req), .bcr_dis_i(dis), .line_o(line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference frame from the mask description of the check bits
  function automatic bit [15:0] ref_frame(input bit [7:0] d);
    bit [4:0] c;
    c[0] = ^(d & 8'h0F);
    c[1] = ^(d & 8'h71);
    c[2] = ^(d & 8'hB6);
    c[3] = ^(d & 8'hDA);
    c[4] = (^d) ^ (^c[3:0]);
    return {2'b00, d, c[4], c[3], c[2], c[1], c[0], 1'b1};
  endfunction

  // ---------------- behavioural reference model ----------------
  int  m_ph, m_orbit, m_last;
  bit  m_line, m_a, m_b, m_bpend, m_spend, m_gap, m_rprev, m_wrap, m_edge;
  bit [7:0]  m_sbyte;
  bit [15:0] m_fr;
  bit        bq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_line = 0; m_a = 0; m_b = 1; m_orbit = 0; m_bpend = 0;
      m_spend = 0; m_sbyte = 0; m_gap = 0; m_rprev = 0; m_last = -1;
      bq.delete();
    end else begin
      m_edge = req && !m_rprev;
      if (m_ph == 0 || m_ph == 2) m_line = !m_line;
      else if (m_ph == 1 && m_a)  m_line = !m_line;
      else if (m_ph == 3 && m_b)  m_line = !m_line;
      if (m_ph == 3) begin
        m_wrap  = (m_orbit == ORBIT - 1);
        m_orbit = m_wrap ? 0 : m_orbit + 1;
        if (bq.size() > 0) begin
          m_b = bq.pop_front();
          if (bq.size() == 0) m_gap = 1;
        end else if (m_gap) begin
          m_b = 1; m_gap = 0;
        end else if (m_bpend || m_spend) begin
          m_fr = ref_frame(m_bpend ? 8'h01 : m_sbyte);
          if (m_bpend) m_bpend = 0; else m_spend = 0;
          for (int i = 15; i >= 0; i--) bq.push_back(m_fr[i]);
          m_b = bq.pop_front();
        end else begin
          m_b = 1;
        end
        m_a = trig;
        if (m_wrap && !dis) m_bpend = 1;
      end
      if (m_edge) begin m_spend = 1; m_sbyte = cmd; end
      m_rprev = req;
      m_last  = m_ph;
      m_ph    = (m_ph + 1) % 4;
    end
  end

  // ---------------- per-clock compare and line decoder ----------------
  bit        s[4];
  bit        in_frame = 0, seen_frame = 0, bbit;
  int        nbits = 0, idle_run = 0;
  bit [15:0] fb;
  bit [7:0]  dec_q[$];

  always @(negedge clk) begin
    if (rst_n && m_last >= 0 && !done) begin
      checks++;
      if (line !== m_line) begin
        errors++;
        $display("FAIL %s phase %0d at %0t: line_o=%0b expected %0b",
                 (m_last == 1) ? "R3" : (m_last == 3) ? "R4" : "R2",
                 m_last, $time, line, m_line);
      end
      s[m_last] = line;
      if (m_last == 3) begin
        bbit = s[3] ^ s[2];
        if (!in_frame) begin
          if (!bbit) begin
            checks++;
            if (seen_frame && idle_run < 1) begin
              errors++;
              $display("FAIL R10 idle bits before start: %0d expected >= 1", idle_run);
            end
            in_frame = 1; fb = 16'h0000; nbits = 1;
          end else begin
            idle_run++;
          end
        end else begin
          fb = {fb[14:0], bbit};
          nbits++;
          if (nbits == 16) begin
            in_frame = 0; seen_frame = 1; idle_run = 0;
            checks++;
            if (fb !== ref_frame(fb[13:6])) begin
              errors++;
              $display("FAIL R5 frame %h expected %h", fb, ref_frame(fb[13:6]));
            end
            dec_q.push_back(fb[13:6]);
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  bit [15:0] lfsr = 16'hACE1;
  bit [7:0]  exp_cmd [8] = '{8'h28, 8'h02, 8'hA5, 8'h3C, 8'h01, 8'h5A, 8'h01, 8'h01};
  string     exp_tag [8] = '{"R8", "R8", "R8", "R10", "R6", "R9", "R6", "R7"};
  int        nbcr;

  initial begin
    #(3*CLK_PERIOD);
    checks++;
    if (line !== 1'b0) begin
      errors++;
      $display("FAIL R1 line_o during reset=%0b expected 0", line);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < TOTAL; b++) begin
      trig = (b >= 10 && b < 14000) ? lfsr[0] : 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req = 1'b0;
      if (b >= 300  && b < 400)  begin req = 1'b1; cmd = 8'h28; end
      if (b >= 500  && b < 520)  begin req = 1'b1; cmd = 8'h02; end
      if (b >= 600  && b < 602)  begin req = 1'b1; cmd = 8'hA5; end
      if (b >= 603  && b < 606)  begin req = 1'b1; cmd = 8'h3C; end
      if (b >= 3563 && b < 3570) begin req = 1'b1; cmd = 8'h5A; end
      dis = (b >= 2*ORBIT + 100 && b < 3*ORBIT + 100);
      repeat (4) @(negedge clk);
    end
    // frame list: order, content and suppression (R6 R7 R8 R9 R10)
    checks++;
    if (dec_q.size() != 8) begin
      errors++;
      $display("FAIL R8 decoded frame count=%0d expected 8", dec_q.size());
    end
    for (int i = 0; i < 8 && i < dec_q.size(); i++) begin
      checks++;
      if (dec_q[i] !== exp_cmd[i]) begin
        errors++;
        $display("FAIL %s frame %0d cmd=%h expected %h", exp_tag[i], i, dec_q[i], exp_cmd[i]);
      end
    end
    nbcr = 0;
    foreach (dec_q[i]) if (dec_q[i] == 8'h01) nbcr++;
    checks++;
    if (nbcr != 3) begin
      errors++;
      $display("FAIL R7 reset frames=%0d expected 3", nbcr);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: run incomplete, expected end of stimulus");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule